// File: doc/BRIEF.md
# Windowed Watchdog Timer

A watchdog peripheral built around a down-counter that loads from a programmable time value and drops by one every clock. Software keeps the system alive by writing a fixed key to the service register. A service write is only honoured once the count has fallen to or below the early-warning level. While the count is still above that level the block is in its closed window, and a keyed write there is either dropped or, if software has chosen so, treated as a fault that trips the watchdog.

Two programmable levels shape the countdown. When the count reaches the early-warning level, a sticky flag is set and can drive a maskable interrupt. A separate enable covers the time the CPU is asleep. When the count reaches the trip level, the non-maskable interrupt is raised and latched. The same happens if the count reaches zero without the trip level having fired. Once the count reaches zero with the non-maskable interrupt pending, the block pulses its system-reset output for one cycle and reloads. A separate kick register gives software a direct path. One key value requests an immediate reset, and any other value trips the non-maskable interrupt at once. The first accepted service write locks the configuration registers.

The register bus is word-addressed: word index k is byte offset 4k. Reads return data combinationally for the index on the address lines.

Top module: `wdt_window`

## Requirements
- R1: After reset the count equals TIME_INIT. The time, early-warning level and trip level registers read TIME_INIT, WARN_INIT and TRIG_INIT. Control reads 0x2, status reads 0x4 when TIME_INIT > WARN_INIT, and all three outputs are low. The word indices are: 0 service/count, 1 control, 2 status, 3 time, 4 early-warning level, 5 trip level, 6 kick (reads 0).
- R2: While running, the count drops by one on each clock edge. It holds at zero.
- R3: Writing 0xDEADC0DE to index 0 while count <= early-warning level reloads the count from the time register on that edge. It also sets the lock flag, status bit 4.
- R4: Status bit 2 reads 1 exactly when count > early-warning level. A keyed write in that state with control bit 4 clear is ignored, and so is any non-key value written to index 0. In both cases the count keeps decrementing and lock stays clear.
- R5: With control bit 4 set, a keyed write while count > early-warning level raises nmi_out on that edge. It also sets status bits 1 and 3, and it does not reload the count.
- R6: Status bit 0 is set on the edge where the count becomes equal to the early-warning level. warn_irq = bit0 AND (control bit 0 OR (cpu_sleep AND control bit 2)).
- R7: nmi_out and status bits 1 and 3 are set on the edge where the count becomes equal to the trip level. If the count sits at zero with nmi_out low, nmi_out is set on the next edge.
- R8: When the count is zero and nmi_out is high, the next edge pulses sys_reset high for exactly one cycle. On that edge the count reloads from the time register and status bits 0 and 1 clear; status bit 3 stays set.
- R9: Writing 0x0C to index 6 pulses sys_reset on that edge and reloads the count. Writing any other value to index 6 raises nmi_out and sets status bits 1, 3 and 5.
- R10: Writing index 2 with data bit 0 or bit 1 set clears status bit 0 or bit 1 respectively.
- R11: Control bit 1 always reads 1. Once lock is set it stays set until reset, and writes to indices 1, 3, 4 and 5 leave those registers unchanged.
- R12: With cpu_sleep high and control bit 3 clear, the count holds. With control bit 3 set, the count keeps dropping during sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word index |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cpu_sleep | input | 1 | CPU is in sleep |
| warn_irq | output | 1 | Maskable early-warning interrupt |
| nmi_out | output | 1 | Non-maskable interrupt |
| sys_reset | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with an 8-bit counter, a time value of 40, an early-warning level of 20 and a trip level of 10. With these values a whole countdown takes only tens of cycles. That makes it affordable to reset and place a keyed service write at every count from 40 down to 2, which covers both sides of the closed-window boundary exactly. The short count also brings within reach the zero-count reset pulse, the case where the trip level sits above the time value, and the locking of each configuration register after the first accepted service write.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int CNT_W = 32,
  parameter int ADDR_W = 3,
  parameter int unsigned TIME_INIT = 32'd1_000_000,
  parameter int unsigned WARN_INIT = 32'd250_000,
  parameter int unsigned TRIG_INIT = 32'd100_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cpu_sleep,
  output logic              warn_irq,
  output logic              nmi_out,
  output logic              sys_reset
);
  localparam logic [31:0] SERVICE_KEY = 32'hDEAD_C0DE;
  localparam logic [31:0] KICK_KEY = 32'h0000_000C;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [ADDR_W-1:0] IX_SVC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IX_CTL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_STS  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IX_TIME = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IX_WARN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] IX_TRIP = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] IX_KICK = ADDR_W'(6);

  logic [CNT_W-1:0] cnt, time_q, warn_q, trig_q;
  logic [4:0] ctrl_q;
  logic warn_f, nmi_f, trip_f, lock_f, kick_f, rst_q;

  wire wr_svc  = bus_we && bus_addr == IX_SVC;
  wire wr_ctl  = bus_we && bus_addr == IX_CTL;
  wire wr_sts  = bus_we && bus_addr == IX_STS;
  wire wr_time = bus_we && bus_addr == IX_TIME;
  wire wr_warn = bus_we && bus_addr == IX_WARN;
  wire wr_trip = bus_we && bus_addr == IX_TRIP;
  wire wr_kick = bus_we && bus_addr == IX_KICK;

  wire run      = !cpu_sleep || ctrl_q[3];
  wire tick     = run && cnt != '0;
  wire [CNT_W-1:0] cnt_dec = cnt - ONE;
  wire closed   = cnt > warn_q;
  wire key_ok   = bus_wdata == SERVICE_KEY;
  wire svc_ok   = wr_svc && key_ok && !closed;
  wire svc_bad  = wr_svc && key_ok && closed && ctrl_q[4];
  wire kick_rst = wr_kick && bus_wdata == KICK_KEY;
  wire kick_nmi = wr_kick && bus_wdata != KICK_KEY;
  wire zero_rst = nmi_f && cnt == '0;
  wire zero_nmi = !nmi_f && cnt == '0;
  wire warn_hit = tick && cnt_dec == warn_q;
  wire trip_hit = tick && cnt_dec == trig_q;
  wire do_rst   = kick_rst || zero_rst;
  wire nmi_set  = trip_hit || zero_nmi || svc_bad || kick_nmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= CNT_W'(TIME_INIT);
      time_q <= CNT_W'(TIME_INIT);
      warn_q <= CNT_W'(WARN_INIT);
      trig_q <= CNT_W'(TRIG_INIT);
      ctrl_q <= 5'b00010;
      warn_f <= 1'b0;
      nmi_f  <= 1'b0;
      trip_f <= 1'b0;
      lock_f <= 1'b0;
      kick_f <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= do_rst;
      if (do_rst || svc_ok) cnt <= time_q;
      else if (tick) cnt <= cnt_dec;
      if (svc_ok) lock_f <= 1'b1;
      if (!lock_f) begin
        if (wr_time) time_q <= bus_wdata[CNT_W-1:0];
        if (wr_warn) warn_q <= bus_wdata[CNT_W-1:0];
        if (wr_trip) trig_q <= bus_wdata[CNT_W-1:0];
        if (wr_ctl)  ctrl_q <= {bus_wdata[4:2], 1'b1, bus_wdata[0]};
      end
      if (do_rst) warn_f <= 1'b0;
      else if (warn_hit) warn_f <= 1'b1;
      else if (wr_sts && bus_wdata[0]) warn_f <= 1'b0;
      if (do_rst) nmi_f <= 1'b0;
      else if (nmi_set) nmi_f <= 1'b1;
      else if (wr_sts && bus_wdata[1]) nmi_f <= 1'b0;
      if (nmi_set) trip_f <= 1'b1;
      if (kick_nmi) kick_f <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      IX_SVC:  bus_rdata = 32'(cnt);
      IX_CTL:  bus_rdata = {27'd0, ctrl_q};
      IX_STS:  bus_rdata = {26'd0, kick_f, lock_f, trip_f, closed, nmi_f, warn_f};
      IX_TIME: bus_rdata = 32'(time_q);
      IX_WARN: bus_rdata = 32'(warn_q);
      IX_TRIP: bus_rdata = 32'(trig_q);
      default: bus_rdata = 32'd0;
    endcase
  end

  assign warn_irq  = warn_f && (ctrl_q[0] || (cpu_sleep && ctrl_q[2]));
  assign nmi_out   = nmi_f;
  assign sys_reset = rst_q;
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
  parameter int CNT_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              cpu_sleep,
  input logic              nmi_out,
  input logic              sys_reset,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  time_q,
  input logic [CNT_W-1:0]  warn_q,
  input logic [CNT_W-1:0]  trig_q,
  input logic              ctrl3,
  input logic              lock_f
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [ADDR_W-1:0] IX_SVC = ADDR_W'(0);

  p_decr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_sleep && !bus_we && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  p_hold_sleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sleep && !ctrl3 && !bus_we && cnt != '0) |=> $stable(cnt));

  p_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == IX_SVC && bus_wdata == 32'hDEAD_C0DE && cnt <= warn_q)
      |=> (cnt == $past(time_q) && lock_f));

  p_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && (!cpu_sleep || ctrl3) && cnt != '0 && (cnt - ONE) == trig_q) |=> nmi_out);

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_f |=> lock_f);

  p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> !nmi_out);
endmodule

bind wdt_window wdt_window_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .cpu_sleep(cpu_sleep), .nmi_out(nmi_out),
  .sys_reset(sys_reset), .cnt(cnt), .time_q(time_q), .warn_q(warn_q),
  .trig_q(trig_q), .ctrl3(ctrl_q[3]), .lock_f(lock_f)
);

// File: tb/tb_wdt_window.sv
`timescale 1ns/1ps
module tb_wdt_window;
  localparam int T0 = 40, W0 = 20, G0 = 10;
  localparam logic [2:0] SVC = 0, CTL = 1, STS = 2, TIM = 3, WRN = 4, TRP = 5, KCK = 6;
  localparam logic [31:0] KEY = 32'hDEAD_C0DE;

  logic clk = 0, rst_n = 0, bus_we = 0, cpu_sleep = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic warn_irq, nmi_out, sys_reset;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] d;

  wdt_window #(.CNT_W(8), .ADDR_W(3), .TIME_INIT(T0), .WARN_INIT(W0), .TRIG_INIT(G0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_sleep(cpu_sleep), .warn_irq(warn_irq),
    .nmi_out(nmi_out), .sys_reset(sys_reset));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    bus_addr = a; bus_wdata = v; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_we = 0; cpu_sleep = 0;
    step(2);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    rd(SVC, d); chk("R1 count", d, T0);
    rd(CTL, d); chk("R1 control", d, 32'h2);
    rd(STS, d); chk("R1 status", d, 32'h4);
    rd(TIM, d); chk("R1 time", d, T0);
    rd(WRN, d); chk("R1 warn level", d, W0);
    rd(TRP, d); chk("R1 trip level", d, G0);
    rd(KCK, d); chk("R1 kick read", d, 0);
    chk("R1 outputs", {29'd0, warn_irq, nmi_out, sys_reset}, 0);

    step(5); rd(SVC, d); chk("R2 decrement", d, T0 - 5);

    cpu_sleep = 1;
    step(4); rd(SVC, d); chk("R12 hold in sleep", d, T0 - 5);
    wr(CTL, 32'h8); rd(SVC, d); chk("R12 hold on write edge", d, T0 - 5);
    rd(CTL, d); chk("R11 control bit1", d, 32'hA);
    step(3); rd(SVC, d); chk("R12 run in sleep", d, T0 - 8);
    cpu_sleep = 0;

    for (int k = 0; k <= T0 - 2; k++) begin
      do_reset();
      step(k);
      wr(SVC, KEY);
      rd(SVC, d);
      if (T0 - k <= W0) begin
        chk("R3 accepted service reload", d, T0);
        rd(STS, d); chk("R3 lock set", d & 32'h10, 32'h10);
      end else begin
        chk("R4 closed-window service ignored", d, T0 - k - 1);
        rd(STS, d); chk("R4 lock clear", d & 32'h10, 0);
      end
    end

    do_reset();
    step(25); wr(SVC, 32'hDEAD_C0DF);
    rd(SVC, d); chk("R4 wrong key ignored", d, T0 - 26);
    rd(STS, d); chk("R4 wrong key no lock", d & 32'h10, 0);

    do_reset();
    wr(CTL, 32'h10); wr(SVC, KEY);
    chk("R5 nmi on closed service", nmi_out, 1);
    rd(SVC, d); chk("R5 no reload", d, T0 - 2);
    rd(STS, d); chk("R5 status", d, 32'hE);

    do_reset();
    wr(CTL, 32'h1); step(T0 - 1 - W0 - 1);
    chk("R6 warn not yet", warn_irq, 0);
    step(1); chk("R6 warn at level", warn_irq, 1);
    rd(STS, d); chk("R6 status bit0", d & 1, 1);
    wr(STS, 32'h1); chk("R10 warn cleared", warn_irq, 0);
    rd(STS, d); chk("R10 status bit0 clear", d & 1, 0);

    do_reset();
    wr(CTL, 32'h4); step(T0 - 1 - W0);
    chk("R6 awake mask", warn_irq, 0);
    rd(STS, d); chk("R6 flag set while masked", d & 1, 1);
    cpu_sleep = 1; #0.1;
    chk("R6 sleep enable", warn_irq, 1);
    cpu_sleep = 0;

    do_reset();
    step(T0 - G0 - 1); chk("R7 nmi not yet", nmi_out, 0);
    step(1); chk("R7 nmi at trip level", nmi_out, 1);
    rd(STS, d); chk("R7 status", d & 32'hA, 32'hA);
    step(G0); rd(SVC, d); chk("R2 reaches zero", d, 0);
    chk("R8 no reset yet", sys_reset, 0);
    step(1); chk("R8 reset pulse", sys_reset, 1);
    rd(SVC, d); chk("R8 reload", d, T0);
    chk("R8 nmi cleared", nmi_out, 0);
    step(1); chk("R8 pulse one cycle", sys_reset, 0);
    rd(STS, d); chk("R8 status after", d, 32'hC);

    do_reset();
    step(T0 - G0); wr(STS, 32'h2);
    chk("R10 nmi cleared", nmi_out, 0);

    do_reset();
    wr(TRP, 50); step(T0 - 1);
    rd(SVC, d); chk("R2 hold at zero", d, 0);
    chk("R7 no nmi before zero", nmi_out, 0);
    step(1); chk("R7 nmi from zero", nmi_out, 1);
    step(1); chk("R8 reset after zero nmi", sys_reset, 1);

    do_reset();
    step(3); wr(KCK, 32'hC);
    chk("R9 kick reset", sys_reset, 1);
    rd(SVC, d); chk("R9 kick reload", d, T0);
    step(1); chk("R9 kick pulse ends", sys_reset, 0);
    do_reset();
    wr(KCK, 32'h5);
    chk("R9 kick nmi", nmi_out, 1);
    chk("R9 no reset", sys_reset, 0);
    rd(STS, d); chk("R9 kick status", d, 32'h2E);

    do_reset();
    wr(TIM, 30); rd(TIM, d); chk("R11 time write before lock", d, 30);
    wr(CTL, 0); rd(CTL, d); chk("R11 control bit1 sticks", d, 32'h2);
    step(T0 - 2 - W0); wr(SVC, KEY);
    rd(SVC, d); chk("R3 reload from new time", d, 30);
    wr(TIM, 7); wr(WRN, 3); wr(TRP, 3); wr(CTL, 1);
    rd(TIM, d); chk("R11 time locked", d, 30);
    rd(WRN, d); chk("R11 warn locked", d, W0);
    rd(TRP, d); chk("R11 trip locked", d, G0);
    rd(CTL, d); chk("R11 control locked", d, 32'h2);
    rd(SVC, d); chk("R2 count after locked writes", d, 26);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule